// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block runs one acquisition unit that sits between a sample source and a DMA buffer. While it waits for a trigger, it keeps a rolling history of incoming samples. When a trigger arrives, it emits up to a programmed number of the newest history samples, oldest first. It then forwards a programmed number of post-trigger samples. At the end of a capture it can flush pending data and terminate the active DMA buffer without software help. When that automatic step is off, software sends a one-shot terminate command instead.

Software sets up the unit while it is disabled. The setup is the pre-trigger count, the post-trigger count, an external-trigger enable and an auto-terminate enable. Software then raises the unit enable. Triggers come from a synchronous software pulse, which always works, or from an asynchronous external line. The external line is synchronised and acts only on its rising edge. A trigger that arrives while a capture is still being emitted is lost and flagged. Two units that share one memory port must both be idle before either starts, so the unit only starts in a cycle where its peer is reported inactive.

Top module: `capture_seq`

## Requirements
- R1: After reset, busy, out_valid, out_flush, out_term and err_missed are all 0.
- R2: The unit becomes active only in a cycle where unit_en is 1 and peer_active is 0. Once active, it stays active while unit_en is 1. busy is 0 at the first clock edge after that cycle and 1 from the second edge on. While peer_active holds the start off, busy stays 0.
- R3: cfg_pre, cfg_post, cfg_ext_en and cfg_auto_term are taken only while the unit is inactive. Changes made while it is active have no effect on captures.
- R4: A one-cycle sw_trig pulse starts a capture whenever the unit is armed. ext_trig starts a capture only if cfg_ext_en was 1 when the unit became active.
- R5: ext_trig acts only on a rising edge. A line held high starts exactly one capture.
- R6: On a trigger, the unit emits on out_valid/out_data the newest min(stored, cfg_pre) history samples, oldest first. It then emits the next cfg_post valid samples, in arrival order. A sample presented in the trigger cycle counts as history.
- R7: If fewer samples are stored than cfg_pre, as happens when the trigger comes early after arming, only the stored ones are emitted, with no padding.
- R8: A trigger while the unit is emitting a capture, or flushing, sets err_missed, which stays set. A trigger while armed does not set it.
- R9: err_missed returns to 0 by the second clock edge after unit_en falls, and busy is 0 at that same edge.
- R10: With auto-terminate on, the end of a capture produces a single-cycle out_flush pulse, then a single-cycle out_term pulse in the next cycle. The unit then re-arms with an empty history.
- R11: With auto-terminate off, no flush or terminate follows a capture. A sw_term pulse while active gives out_flush one cycle later and out_term the cycle after that.
- R12: busy is 1 whenever the unit is armed, capturing or flushing, and 0 only while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit enable |
| peer_active | input | 1 | The other unit on the shared memory port is active |
| cfg_pre | input | CNT_W | Pre-trigger sample count |
| cfg_post | input | POST_W | Post-trigger sample count |
| cfg_ext_en | input | 1 | Allow the external trigger |
| cfg_auto_term | input | 1 | Flush and terminate automatically at capture end |
| sw_trig | input | 1 | Software trigger pulse |
| sw_term | input | 1 | Software buffer-terminate pulse |
| ext_trig | input | 1 | Asynchronous external trigger line |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DATA_W | Output sample value |
| out_flush | output | 1 | Flush pending data pulse |
| out_term | output | 1 | Terminate active DMA buffer pulse |
| busy | output | 1 | Unit not idle |
| err_missed | output | 1 | Sticky missed-trigger error |

## Verification
busy follows enable by two edges: one for the active flag and one for the state. The bench samples busy on the falling edges after the first and second rising edges. The external trigger spends three edges in the synchroniser and edge detector. History output starts one edge after the trigger, and the last sample is followed by flush two edges later and terminate three edges later. For all of these, the bench drives inputs on falling edges, records outputs on falling edges in a monitor, and checks counts and values only after a settling window several cycles longer than the longest latency. Error clearing and disable are checked at exactly the second falling edge after unit_en drops.

// File: rtl/capture_pkg.sv
package capture_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ARMED = 2'd1,
    CS_POST  = 2'd2,
    CS_FLUSH = 2'd3
  } cap_state_e;

endpackage

// File: rtl/cap_trig_in.sv
module cap_trig_in (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_async,
  input  logic ext_en,
  input  logic sw_pulse,
  output logic trig_o
);

  logic sync1_q, sync2_q, prev_q;

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= ext_async;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  logic ext_rise;
  always_comb begin
    ext_rise = sync2_q & ~prev_q;
    trig_o   = sw_pulse | (ext_en & ext_rise);
  end

endmodule

// File: rtl/cap_history.sv
module cap_history #(
  parameter int DATA_W  = 16,
  parameter int PRE_MAX = 16,
  parameter int CNT_W   = $clog2(PRE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic              post_wr,
  input  logic              post_rd,
  input  logic              take,
  input  logic              fill_clr,
  input  logic [CNT_W-1:0]  pre_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              pend_zero
);

  // two extra slots keep a full history plus one in-flight post sample
  localparam int AW    = $clog2(PRE_MAX + 2);
  localparam int DEPTH = 1 << AW;
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(PRE_MAX);
  localparam int unsigned PEND_LIM = PRE_MAX + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  fill_q, fill_d, take_n;
  logic [AW:0]       pend_q, pend_d, take_w;
  logic              wr, rd;

  always_comb begin
    wr = wr_valid & (arm_wr | post_wr);
    rd = post_rd & (pend_q != '0);
    wp_d = wp_q + AW'(wr);

    fill_d = fill_q;
    if (fill_clr)
      fill_d = '0;
    else if (arm_wr && wr_valid && fill_q != FILL_MAX)
      fill_d = fill_q + 1'b1;

    take_n = (fill_d < pre_n) ? fill_d : pre_n;
    take_w = '0;
    take_w[CNT_W-1:0] = take_n;

    if (take) begin
      rp_d   = wp_d - take_w[AW-1:0];
      pend_d = take_w;
    end else begin
      rp_d   = rp_q + AW'(rd);
      pend_d = pend_q + (AW+1)'(post_wr & wr_valid) - (AW+1)'(rd);
    end
    pend_zero = (pend_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q     <= '0;
      rp_q     <= '0;
      fill_q   <= '0;
      pend_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      wp_q     <= wp_d;
      rp_q     <= rp_d;
      fill_q   <= fill_d;
      pend_q   <= pend_d;
      rd_valid <= rd;
    end
  end

  // storage and read data carry no reset
  always_ff @(posedge clk) begin
    if (wr) mem[wp_q] <= wr_data;
    if (rd) rd_data   <= mem[rp_q];
  end

  // R7: occupancy never reaches the point where a write overtakes unread data
  assert_pend_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pend_q) <= PEND_LIM);

endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import capture_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int POST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              trig,
  input  logic              smp_valid,
  input  logic              pend_zero,
  input  logic              sw_term,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [POST_W-1:0] cfg_post,
  input  logic              cfg_ext_en,
  input  logic              cfg_auto,
  output cap_state_e        state_o,
  output logic [CNT_W-1:0]  pre_o,
  output logic              ext_en_o,
  output logic              arm_wr_o,
  output logic              post_wr_o,
  output logic              post_rd_o,
  output logic              take_o,
  output logic              fill_clr_o,
  output logic              flush_o,
  output logic              term_o,
  output logic              err_o
);

  cap_state_e        state_q, state_d;
  logic [CNT_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q, rem_q, rem_d;
  logic              ext_q, auto_q;
  logic              err_q, err_d, flush_q, flush_d, term_q, term_d;
  logic              rem_zero, done;

  // configuration is captured only while the unit is inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
      ext_q  <= 1'b0;
      auto_q <= 1'b0;
    end else if (!active) begin
      pre_q  <= cfg_pre;
      post_q <= cfg_post;
      ext_q  <= cfg_ext_en;
      auto_q <= cfg_auto;
    end
  end

  always_comb begin
    rem_zero = (rem_q == '0);
    done     = (state_q == CS_POST) && rem_zero && pend_zero;

    state_d = state_q;
    unique case (state_q)
      CS_IDLE:  state_d = CS_ARMED;
      CS_ARMED: if (trig) state_d = CS_POST;
      CS_POST:  if (done) state_d = auto_q ? CS_FLUSH : CS_ARMED;
      CS_FLUSH: state_d = CS_ARMED;
      default:  state_d = CS_IDLE;
    endcase
    if (!active) state_d = CS_IDLE;

    rem_d = rem_q;
    if (state_q == CS_ARMED && trig)
      rem_d = post_q;
    else if (state_q == CS_POST && smp_valid && !rem_zero)
      rem_d = rem_q - 1'b1;

    err_d = err_q;
    if (!active)
      err_d = 1'b0;
    else if (trig && (state_q == CS_POST || state_q == CS_FLUSH))
      err_d = 1'b1;

    flush_d = active & ((done & auto_q) | (sw_term & ~auto_q));
    term_d  = active & flush_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      rem_q   <= '0;
      err_q   <= 1'b0;
      flush_q <= 1'b0;
      term_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      err_q   <= err_d;
      flush_q <= flush_d;
      term_q  <= term_d;
    end
  end

  always_comb begin
    state_o    = state_q;
    pre_o      = pre_q;
    ext_en_o   = ext_q;
    arm_wr_o   = (state_q == CS_ARMED);
    post_wr_o  = (state_q == CS_POST) && !rem_zero;
    post_rd_o  = (state_q == CS_POST);
    take_o     = (state_q == CS_ARMED) && trig;
    fill_clr_o = (state_q != CS_ARMED);
    flush_o    = flush_q;
    term_o     = term_q;
    err_o      = err_q;
  end

  // R3: captured configuration holds while active
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(pre_q) && $stable(post_q) && $stable(auto_q)));

  // R9: error clears once inactive
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !err_q);

  // R12: inactive forces the idle state
  assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state_q == CS_IDLE));

  // R10: terminate always follows a flush by one cycle
  assert_term_after_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |-> $past(flush_q));

  // R10: flush is a single-cycle pulse
  assert_flush_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);

endmodule

// File: rtl/capture_seq.sv
module capture_seq
  import capture_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PRE_MAX  = 16,
  parameter int POST_MAX = 1023,
  localparam int CNT_W   = $clog2(PRE_MAX + 1),
  localparam int POST_W  = $clog2(POST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              peer_active,
  input  logic [CNT_W-1:0]  cfg_pre,
  input  logic [POST_W-1:0] cfg_post,
  input  logic              cfg_ext_en,
  input  logic              cfg_auto_term,
  input  logic              sw_trig,
  input  logic              sw_term,
  input  logic              ext_trig,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flush,
  output logic              out_term,
  output logic              busy,
  output logic              err_missed
);

  logic active_q, active_d;
  logic trig;
  cap_state_e state;
  logic [CNT_W-1:0] pre_q;
  logic ext_en_q, arm_wr, post_wr, post_rd, take, fill_clr, pend_zero;

  // start only when the peer on the shared memory port is inactive
  always_comb active_d = unit_en & (active_q | ~peer_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  cap_trig_in u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_async (ext_trig),
    .ext_en    (ext_en_q),
    .sw_pulse  (sw_trig),
    .trig_o    (trig)
  );

  cap_fsm #(.CNT_W(CNT_W), .POST_W(POST_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active_q),
    .trig       (trig),
    .smp_valid  (smp_valid),
    .pend_zero  (pend_zero),
    .sw_term    (sw_term),
    .cfg_pre    (cfg_pre),
    .cfg_post   (cfg_post),
    .cfg_ext_en (cfg_ext_en),
    .cfg_auto   (cfg_auto_term),
    .state_o    (state),
    .pre_o      (pre_q),
    .ext_en_o   (ext_en_q),
    .arm_wr_o   (arm_wr),
    .post_wr_o  (post_wr),
    .post_rd_o  (post_rd),
    .take_o     (take),
    .fill_clr_o (fill_clr),
    .flush_o    (out_flush),
    .term_o     (out_term),
    .err_o      (err_missed)
  );

  cap_history #(.DATA_W(DATA_W), .PRE_MAX(PRE_MAX), .CNT_W(CNT_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_wr    (arm_wr),
    .post_wr   (post_wr),
    .post_rd   (post_rd),
    .take      (take),
    .fill_clr  (fill_clr),
    .pre_n     (pre_q),
    .wr_valid  (smp_valid),
    .wr_data   (smp_data),
    .rd_valid  (out_valid),
    .rd_data   (out_data),
    .pend_zero (pend_zero)
  );

  always_comb busy = (state != CS_IDLE);

  // R2: activation only happens with the peer reported inactive
  assert_peer_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(!peer_active && unit_en));

  // R6: output samples only come out of the capture state
  assert_valid_in_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(state == CS_POST));

endmodule

// File: tb/tb_capture_seq.sv
module tb_capture_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;
  localparam int POST_W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic unit_en, peer_active, cfg_ext_en, cfg_auto_term;
  logic sw_trig, sw_term, ext_trig, smp_valid;
  logic [CNT_W-1:0]  cfg_pre;
  logic [POST_W-1:0] cfg_post;
  logic [DATA_W-1:0] smp_data;
  logic out_valid, out_flush, out_term, busy, err_missed;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int seq    = 1;
  int ng     = 0;
  int nflush = 0;
  int nterm  = 0;
  int got [64];
  bit done   = 1'b0;

  always #5 clk = ~clk;

  capture_seq dut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .peer_active(peer_active),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_ext_en(cfg_ext_en),
    .cfg_auto_term(cfg_auto_term), .sw_trig(sw_trig), .sw_term(sw_term),
    .ext_trig(ext_trig), .smp_valid(smp_valid), .smp_data(smp_data),
    .out_valid(out_valid), .out_data(out_data), .out_flush(out_flush),
    .out_term(out_term), .busy(busy), .err_missed(err_missed)
  );

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (ng < 64) got[ng] = int'(out_data);
        ng++;
      end
      if (out_flush) nflush++;
      if (out_term)  nterm++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b1;
      smp_data  = DATA_W'(seq);
      seq++;
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic pulse_trig();
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic enable_unit(input int pre, input int post, input bit ext, input bit auto_t);
    unit_en = 1'b0;
    tick(3);
    cfg_pre = CNT_W'(pre);
    cfg_post = POST_W'(post);
    cfg_ext_en = ext;
    cfg_auto_term = auto_t;
    tick(1);
    unit_en = 1'b1;
    tick(3);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 flush/term", int'(out_flush | out_term), 0);
    chk("R1 err", int'(err_missed), 0);
  endtask

  task automatic t_enable_latency();
    cfg_pre = 5'd4; cfg_post = 10'd3; cfg_ext_en = 1'b0; cfg_auto_term = 1'b1;
    tick(1);
    unit_en = 1'b1;
    tick(1);
    chk("R2 busy after one edge", int'(busy), 0);
    tick(1);
    chk("R2 R12 busy after two edges", int'(busy), 1);
    tick(1);
  endtask

  task automatic t_basic();
    int f0 = nflush;
    int t0 = nterm;
    ng = 0; seq = 1;
    send(10);
    pulse_trig();
    send(3);
    tick(10);
    chk("R6 count", ng, 7);
    for (int i = 0; i < 7; i++) chk("R6 data", got[i], 7 + i);
    chk("R10 flush", nflush - f0, 1);
    chk("R10 term", nterm - t0, 1);
    chk("R8 armed trigger no error", int'(err_missed), 0);
    chk("R12 busy re-armed", int'(busy), 1);
  endtask

  task automatic t_early();
    ng = 0;
    send(2);
    pulse_trig();
    send(3);
    tick(10);
    chk("R7 count", ng, 5);
    for (int i = 0; i < 5; i++) chk("R7 data", got[i], 14 + i);
  endtask

  task automatic t_missed();
    ng = 0;
    pulse_trig();
    pulse_trig();
    send(3);
    tick(10);
    chk("R8 missed error set", int'(err_missed), 1);
    chk("R8 capture still completes", ng, 3);
    unit_en = 1'b0;
    tick(2);
    chk("R9 error cleared", int'(err_missed), 0);
    chk("R9 R12 idle after disable", int'(busy), 0);
  endtask

  task automatic t_cfg_latch();
    int t0;
    enable_unit(4, 3, 1'b0, 1'b1);
    cfg_pre = 5'd1; cfg_post = 10'd1; cfg_auto_term = 1'b0;
    t0 = nterm;
    ng = 0; seq = 100;
    send(6);
    pulse_trig();
    send(3);
    tick(10);
    chk("R3 count from latched cfg", ng, 7);
    chk("R3 first sample", got[0], 102);
    chk("R3 auto term kept", nterm - t0, 1);
  endtask

  task automatic t_manual_term();
    int f0, t0;
    enable_unit(2, 2, 1'b0, 1'b0);
    f0 = nflush; t0 = nterm;
    ng = 0; seq = 200;
    send(4);
    pulse_trig();
    send(2);
    tick(10);
    chk("R11 count", ng, 4);
    chk("R11 data", got[0], 202);
    chk("R11 no auto term", nterm - t0, 0);
    sw_term = 1'b1;
    tick(1);
    sw_term = 1'b0;
    chk("R11 flush one edge later", int'(out_flush), 1);
    tick(1);
    chk("R11 term next edge", int'(out_term), 1);
    tick(2);
    chk("R11 single flush", nflush - f0, 1);
    chk("R11 single term", nterm - t0, 1);
  endtask

  task automatic t_ext();
    int base;
    enable_unit(2, 2, 1'b0, 1'b1);
    ng = 0; seq = 300;
    send(5);
    ext_trig = 1'b1;
    tick(5);
    send(2);
    tick(10);
    chk("R4 ext ignored when disabled", ng, 0);
    ext_trig = 1'b0;
    tick(3);
    enable_unit(2, 2, 1'b1, 1'b1);
    ng = 0; seq = 400; base = 400;
    send(5);
    ext_trig = 1'b1;
    tick(5);
    send(2);
    tick(10);
    chk("R4 ext capture count", ng, 4);
    for (int i = 0; i < 4; i++) chk("R4 ext data", got[i], base + 3 + i);
    send(5);
    tick(10);
    chk("R5 held level no retrigger", ng, 4);
    ext_trig = 1'b0;
    tick(2);
  endtask

  task automatic t_peer();
    unit_en = 1'b0;
    tick(3);
    peer_active = 1'b1;
    unit_en = 1'b1;
    tick(4);
    chk("R2 blocked by peer", int'(busy), 0);
    peer_active = 1'b0;
    tick(3);
    chk("R2 starts once peer idle", int'(busy), 1);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    unit_en = 1'b0; peer_active = 1'b0;
    cfg_pre = '0; cfg_post = '0; cfg_ext_en = 1'b0; cfg_auto_term = 1'b0;
    sw_trig = 1'b0; sw_term = 1'b0; ext_trig = 1'b0;
    smp_valid = 1'b0; smp_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_enable_latency();
    t_basic();
    t_early();
    t_missed();
    t_cfg_latch();
    t_manual_term();
    t_ext();
    t_peer();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule